// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter

This block decides who owns a shared external bus that up to six processors reach. One copy sits beside each processor. There is no central arbiter. Every copy drives only the request line that belongs to its own node ID. It watches all six request lines and works out on its own which node is master in every cycle. All copies see the same lines and start from the same reset state, so they always agree on the master without exchanging any other signal.

The current master keeps the bus for as long as its request stays high. The master changes hands in a transition cycle. A transition starts when the master's request is low while some other line is high. It can also start when the tenure limit is reached, or when core-priority access is asserted, in both cases only if another node is requesting. The winner comes from a fixed order or from a rotating order, chosen by a mode pin. A handover costs exactly one overhead cycle. In that cycle no node is granted the bus and no further handover is considered. A lock input freezes ownership so that a read-modify-write sequence cannot be split.

Top module: `mpa_bus_arbiter`

## Requirements
- R1: After reset, node 1 is master, `xfer_cycle` is 0, and the rotating order starts with node 1 as highest priority.
- R2: `req_out` follows `want_bus` combinationally; it is the value this node places on the request line of its own ID.
- R3: Bit k of `req_lines` is the request of node ID k+1. The master keeps ownership while its own line is high (with no tenure limit and no core-priority access). When no line is high, the master keeps ownership and loses no cycle.
- R4: Suppose the master's line is low, another line is high, and the block is neither locked nor in an overhead cycle. Then at the next clock edge `master_id` becomes the winning ID and `xfer_cycle` is 1. `master_id` never changes without `xfer_cycle` being 1.
- R5: With `rot_sel` = 0 (fixed scheme), the requesting node with the lowest ID wins.
- R6: With `rot_sel` = 1 (rotating scheme), the search for a winner starts just after the previous winner and wraps circularly from ID 6 to ID 1. The pointer moves on every handover in either scheme.
- R7: `xfer_cycle` lasts exactly one cycle. During that cycle `granted` is 0 and no new handover can start.
- R8: While `bus_lock` is 1, `master_id` does not change at the next edge.
- R9: A nonzero `tenure_limit` L forces a handover once the master has held the bus for L cycles, if another line is high. An L of 0 means the master may hold the bus indefinitely.
- R10: When `core_pri` is 1 and another line is high, the master gives up the bus even though its own line is still high. With no other requester, `core_pri` has no effect.
- R11: `granted` is 1 exactly when `master_id` equals `node_id` and `xfer_cycle` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 3 | This node's ID, 1 to 6 |
| want_bus | input | 1 | Local processor requests the bus |
| req_lines | input | 6 | Observed request lines, bit k = ID k+1 |
| rot_sel | input | 1 | 1 = rotating priority, 0 = fixed |
| bus_lock | input | 1 | Freezes ownership |
| core_pri | input | 1 | Core-priority access: master yields to a waiting requester |
| tenure_limit | input | 8 | Maximum cycles of tenure, 0 = unlimited |
| req_out | output | 1 | Drive for this node's request line |
| granted | output | 1 | This node owns the bus this cycle |
| master_id | output | 3 | ID of the current master |
| xfer_cycle | output | 1 | High in the overhead cycle of a handover |

## Verification
A stimulus table runs both schemes. It picks request patterns where the fixed order and the rotating order give different winners. This exposes a rotation pointer that is stuck or off by one, and a mode select that is wired backwards.

The table also makes the old master drop its request during the overhead cycle. A design that evaluates handovers during that cycle would hand the bus on twice.

Directed tests cover further corners:
- A held lock followed by its release. A design that ignores the lock moves the master early.
- A tenure limit of 3. A counter that is off by one fires a cycle early or late.
- Core-priority access with and without a waiting requester. A faulty design yields too eagerly or not at all.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
    localparam int unsigned MPA_NODES = 6;
    localparam int unsigned MPA_ID_W  = 3;
    localparam int unsigned MPA_TEN_W = 8;

    typedef enum logic {
        SCHEME_FIXED  = 1'b0,
        SCHEME_ROTATE = 1'b1
    } scheme_e;
endpackage

// File: rtl/mpa_winner_pick.sv
module mpa_winner_pick
    import mpa_pkg::*;
#(
    parameter int unsigned N  = MPA_NODES,
    parameter int unsigned IW = MPA_ID_W
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] start_idx,
    input  scheme_e       scheme,
    output logic [IW-1:0] win_idx,
    output logic          found
);
    logic [IW-1:0] base;
    logic [IW:0]   probe;

    always_comb begin
        base    = (scheme == SCHEME_ROTATE) ? start_idx : '0;
        found   = 1'b0;
        win_idx = '0;
        probe   = '0;
        for (int k = 0; k < N; k++) begin
            probe = {1'b0, base} + (IW+1)'(k);
            if (probe >= (IW+1)'(N)) begin
                probe = probe - (IW+1)'(N);
            end
            if (!found && cand[probe[IW-1:0]]) begin
                found   = 1'b1;
                win_idx = probe[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/mpa_tenure_ctr.sv
module mpa_tenure_ctr
    import mpa_pkg::*;
#(
    parameter int unsigned TW = MPA_TEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          hit
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear) begin
            cnt_d = '0;
        end else if (cnt_q == '1) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit = (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/mpa_bus_arbiter.sv
module mpa_bus_arbiter
    import mpa_pkg::*;
#(
    parameter int unsigned N  = MPA_NODES,
    parameter int unsigned IW = MPA_ID_W,
    parameter int unsigned TW = MPA_TEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] node_id,
    input  logic          want_bus,
    input  logic [N-1:0]  req_lines,
    input  logic          rot_sel,
    input  logic          bus_lock,
    input  logic          core_pri,
    input  logic [TW-1:0] tenure_limit,
    output logic          req_out,
    output logic          granted,
    output logic [IW-1:0] master_id,
    output logic          xfer_cycle
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    typedef struct packed {
        logic [IW-1:0] master_idx;
        logic [IW-1:0] head_idx;
        logic          xfer;
    } arb_state_t;

    arb_state_t    st_d, st_q;
    logic [N-1:0]  master_oh;
    logic [N-1:0]  others;
    logic          master_req;
    logic          yield;
    logic          handover;
    logic          tenure_hit;
    logic          pick_found;
    logic [IW-1:0] pick_idx;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_own
            assign master_oh[g] = (st_q.master_idx == IW'(g));
        end
    endgenerate

    assign others     = req_lines & ~master_oh;
    assign master_req = |(req_lines & master_oh);

    mpa_winner_pick #(.N(N), .IW(IW)) u_pick (
        .cand      (others),
        .start_idx (st_q.head_idx),
        .scheme    (scheme_e'(rot_sel)),
        .win_idx   (pick_idx),
        .found     (pick_found)
    );

    mpa_tenure_ctr #(.TW(TW)) u_tenure (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (handover),
        .limit (tenure_limit),
        .hit   (tenure_hit)
    );

    always_comb begin
        yield    = !master_req || tenure_hit || core_pri;
        handover = !st_q.xfer && !bus_lock && pick_found && yield;
        st_d      = st_q;
        st_d.xfer = handover;
        if (handover) begin
            st_d.master_idx = pick_idx;
            st_d.head_idx   = (pick_idx == LAST_IDX) ? '0 : pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{master_idx: '0, head_idx: '0, xfer: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign master_id  = st_q.master_idx + 1'b1;
    assign xfer_cycle = st_q.xfer;
    assign granted    = (master_id == node_id) && !st_q.xfer;
    assign req_out    = want_bus;
endmodule

// File: rtl/mpa_bus_arbiter_chk.sv
module mpa_bus_arbiter_chk
    import mpa_pkg::*;
#(
    parameter int unsigned N  = MPA_NODES,
    parameter int unsigned IW = MPA_ID_W,
    parameter int unsigned TW = MPA_TEN_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] node_id,
    input logic          want_bus,
    input logic [N-1:0]  req_lines,
    input logic          rot_sel,
    input logic          bus_lock,
    input logic          core_pri,
    input logic [TW-1:0] tenure_limit,
    input logic          req_out,
    input logic          granted,
    input logic [IW-1:0] master_id,
    input logic          xfer_cycle
);
    logic [IW-1:0] cur_idx;
    assign cur_idx = master_id - 1'b1;

    p_single_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cycle |=> !xfer_cycle);

    p_no_grant_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cycle |-> !granted);

    p_move_needs_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(master_id) |-> xfer_cycle);

    p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_cycle && !bus_lock && !req_lines[cur_idx] && (req_lines != '0))
        |=> xfer_cycle);

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |=> $stable(master_id));

    p_idle_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lines == '0) |=> $stable(master_id));

    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lines[cur_idx] && !core_pri && (tenure_limit == '0))
        |=> $stable(master_id));
endmodule

bind mpa_bus_arbiter mpa_bus_arbiter_chk #(.N(N), .IW(IW), .TW(TW)) u_chk (.*);

// File: tb/tb_mpa_bus_arbiter.sv
module tb_mpa_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] node_id;
    logic       want_bus;
    logic [5:0] req_lines;
    logic       rot_sel;
    logic       bus_lock;
    logic       core_pri;
    logic [7:0] tenure_limit;
    logic       req_out;
    logic       granted;
    logic [2:0] master_id;
    logic       xfer_cycle;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mpa_bus_arbiter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .node_id      (node_id),
        .want_bus     (want_bus),
        .req_lines    (req_lines),
        .rot_sel      (rot_sel),
        .bus_lock     (bus_lock),
        .core_pri     (core_pri),
        .tenure_limit (tenure_limit),
        .req_out      (req_out),
        .granted      (granted),
        .master_id    (master_id),
        .xfer_cycle   (xfer_cycle)
    );

    // {rot, req[5:0], master, xfer, granted}; node_id = 3
    localparam logic [11:0] VECS [14] = '{
        {1'b0, 6'b000001, 3'd1, 1'b0, 1'b0},  // R3 holder keeps
        {1'b0, 6'b000101, 3'd1, 1'b0, 1'b0},  // R3 keeps while others wait
        {1'b0, 6'b000100, 3'd3, 1'b1, 1'b0},  // R4 handover, R7 no grant
        {1'b0, 6'b000100, 3'd3, 1'b0, 1'b1},  // R11 granted
        {1'b0, 6'b000000, 3'd3, 1'b0, 1'b1},  // R3 park
        {1'b0, 6'b110010, 3'd2, 1'b1, 1'b0},  // R5 lowest ID
        {1'b0, 6'b110000, 3'd2, 1'b0, 1'b0},  // R7 no handover in overhead
        {1'b0, 6'b110000, 3'd5, 1'b1, 1'b0},  // R5
        {1'b1, 6'b100010, 3'd5, 1'b0, 1'b0},  // R7 blocked
        {1'b1, 6'b100010, 3'd6, 1'b1, 1'b0},  // R6 start after 5
        {1'b1, 6'b001100, 3'd6, 1'b0, 1'b0},  // R7
        {1'b1, 6'b001100, 3'd3, 1'b1, 1'b0},  // R6 wrap to 1, picks 3
        {1'b1, 6'b001010, 3'd3, 1'b0, 1'b1},  // R7 overhead, R11
        {1'b1, 6'b001010, 3'd4, 1'b1, 1'b0}   // R6 start after 3
    };

    task automatic chk(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic [2:0] id);
        rst_n        = 1'b0;
        node_id      = id;
        want_bus     = 1'b0;
        req_lines    = '0;
        rot_sel      = 1'b0;
        bus_lock     = 1'b0;
        core_pri     = 1'b0;
        tenure_limit = '0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(3'd3);
        chk("R1 master", int'(master_id), 1);
        chk("R1 xfer", int'(xfer_cycle), 0);
        chk("R11 grant other node", int'(granted), 0);
        node_id = 3'd1;
        #1;
        chk("R11 grant node1", int'(granted), 1);
        node_id = 3'd3;

        // R2 request drive
        want_bus = 1'b1;
        #1;
        chk("R2 req_out high", int'(req_out), 1);
        want_bus = 1'b0;
        #1;
        chk("R2 req_out low", int'(req_out), 0);

        // table
        for (int i = 0; i < 14; i++) begin
            rot_sel   = VECS[i][11];
            req_lines = VECS[i][10:5];
            step();
            chk($sformatf("R4/R5/R6 vec%0d master", i), int'(master_id), int'(VECS[i][4:2]));
            chk($sformatf("R7 vec%0d xfer", i), int'(xfer_cycle), int'(VECS[i][1]));
            chk($sformatf("R11 vec%0d grant", i), int'(granted), int'(VECS[i][0]));
        end

        // R8 lock
        do_reset(3'd2);
        req_lines = 6'b000010;
        bus_lock  = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 locked master", int'(master_id), 1);
        end
        bus_lock = 1'b0;
        step();
        chk("R8 release master", int'(master_id), 2);
        chk("R7 release xfer", int'(xfer_cycle), 1);
        chk("R7 grant during overhead", int'(granted), 0);
        step();
        chk("R11 grant after overhead", int'(granted), 1);
        chk("R7 xfer single", int'(xfer_cycle), 0);

        // R9 tenure limit
        do_reset(3'd3);
        tenure_limit = 8'd3;
        req_lines    = 6'b000011;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R9 within tenure", int'(master_id), 1);
        end
        step();
        chk("R9 tenure expiry master", int'(master_id), 2);
        chk("R9 tenure expiry xfer", int'(xfer_cycle), 1);

        // R9 unlimited
        do_reset(3'd3);
        req_lines = 6'b000011;
        for (int i = 0; i < 10; i++) step();
        chk("R9 zero limit holds", int'(master_id), 1);

        // R10 core-priority access
        do_reset(3'd3);
        req_lines = 6'b000001;
        core_pri  = 1'b1;
        step();
        chk("R10 no other requester", int'(master_id), 1);
        chk("R10 no xfer alone", int'(xfer_cycle), 0);
        req_lines = 6'b000011;
        step();
        chk("R10 yields master", int'(master_id), 2);
        chk("R10 yields xfer", int'(xfer_cycle), 1);

        // R1 rotating start after reset
        do_reset(3'd3);
        rot_sel   = 1'b1;
        req_lines = 6'b100100;
        step();
        chk("R1 rotating after reset", int'(master_id), 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule